// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block drives a 12-bit successive-approximation converter whose conversions run for a fixed fourteen clock cycles. A client places conversion requests, each carrying a one-hot input channel word and a reference pair code, on a valid/ready port. The sequencer moves the channel and reference selects onto the converter only in the cycles where the converter tolerates a change. It pulses start-of-conversion and follows the converter's cycle count. When end-of-conversion arrives it captures the 12-bit result and returns it with its channel on a second valid/ready port.

One request can wait in a holding register while a conversion runs. Its channel word reaches the converter during the middle of the running conversion and its reference code during the final cycle. The next start can then be issued in cycle 14, so a client that keeps its request valid gets conversions back to back at the converter's full rate. A start is held back while an unread result would otherwise be overwritten.

Top module: `sar_conv_seq`

## Requirements
- R1: While rst_ni is low and just after it is released, adc_soc_o and res_valid_o are 0, adc_chan_sel_o and adc_ref_sel_o are 0, and req_ready_o is 1.
- R2: For a request that arrives while the converter is idle, adc_chan_sel_o and adc_ref_sel_o carry the request's values in the cycle in which adc_soc_o goes high. adc_soc_o is high for one cycle per conversion.
- R3: A conversion lasts 14 cycles, and res_valid_o goes high 14 cycles after the cycle in which adc_soc_o was high.
- R4: The converter raises adc_eoc_i in cycle 13 of each conversion. At the end of that cycle the sequencer captures adc_data_i into res_data_o and the conversion's channel word into res_chan_o.
- R5: adc_chan_sel_o never takes a new value in cycle 1 or cycle 14 of a conversion. Mid-conversion updates appear only in cycles 3 to 13.
- R6: adc_ref_sel_o holds one value from cycle 1 to cycle 13 of a conversion. During a conversion it changes only into cycle 14, after adc_eoc_i has been seen.
- R7: When requests are offered without a break and res_ready_i stays 1, adc_soc_o goes high every 14 cycles. Results come back in request order.
- R8: An accepted request that has not yet reached the converter selects keeps req_ready_o at 0.
- R9: While res_valid_o is 1 and res_ready_i is 0, res_data_o and res_chan_o stay stable and no new conversion starts.
- R10: With no request pending, adc_soc_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, shared with the converter |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Conversion request valid |
| req_ready_o | output | 1 | Holding register free |
| req_chan_i | input | 12 | Requested one-hot channel word |
| req_ref_i | input | 2 | Requested reference pair code |
| adc_soc_o | output | 1 | Start-of-conversion to the converter |
| adc_eoc_i | input | 1 | End-of-conversion from the converter |
| adc_data_i | input | 12 | Converter result |
| adc_chan_sel_o | output | 12 | Converter input multiplexer select |
| adc_ref_sel_o | output | 2 | Converter reference select |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result accepted by the sink |
| res_data_o | output | 12 | Captured result |
| res_chan_o | output | 12 | Channel word of the captured result |

## Verification
The assertions assume that the converter runs in lockstep with the sequencer's own counter. They also assume that adc_eoc_i is high only in cycle 13 of a conversion that the sequencer started. The bench meets both assumptions with a behavioural converter that starts its count from adc_soc_o and derives end-of-conversion and its data from that count and from the selects it latched at start. res_ready_i is driven only between clock edges and may be low for long stretches. The model also flags any select change that falls in a forbidden cycle.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int unsigned DATA_W  = 12;
  localparam int unsigned CHAN_W  = 12;
  localparam int unsigned REF_W   = 2;
  localparam int unsigned NUM_CYC = 14;
endpackage

// File: rtl/sar_cycle_cnt.sv
module sar_cycle_cnt #(
  parameter int unsigned NUM_CYC = 14,
  parameter int unsigned CNT_W   = $clog2(NUM_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [CNT_W-1:0] cyc_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_CYC);

  logic [CNT_W-1:0] cyc_q;

  // 0 = idle, 1..NUM_CYC = converter cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cyc_q <= '0;
    else if (start_i)                   cyc_q <= CNT_W'(1);
    else if (cyc_q != '0 && cyc_q < LAST) cyc_q <= cyc_q + 1'b1;
    else                                cyc_q <= '0;
  end

  assign cyc_o = cyc_q;

  assert_cyc_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q <= LAST);

  assert_cyc_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != '0 && cyc_q < LAST) |=> cyc_q == $past(cyc_q) + 1'b1);
endmodule

// File: rtl/sar_req_hold.sv
module sar_req_hold #(
  parameter int unsigned CHAN_W = 12,
  parameter int unsigned REF_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [CHAN_W-1:0] req_chan_i,
  input  logic [REF_W-1:0]  req_ref_i,
  input  logic              take_i,
  output logic              pend_vld_o,
  output logic [CHAN_W-1:0] pend_chan_o,
  output logic [REF_W-1:0]  pend_ref_o
);
  logic              vld_q;
  logic [CHAN_W-1:0] chan_q;
  logic [REF_W-1:0]  ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      chan_q <= '0;
      ref_q  <= '0;
    end else if (!vld_q && req_valid_i) begin
      vld_q  <= 1'b1;
      chan_q <= req_chan_i;
      ref_q  <= req_ref_i;
    end else if (take_i) begin
      vld_q  <= 1'b0;
    end
  end

  assign req_ready_o = !vld_q;
  assign pend_vld_o  = vld_q;
  assign pend_chan_o = chan_q;
  assign pend_ref_o  = ref_q;

  assert_hold_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !take_i) |=> (!req_ready_o && $stable(chan_q) && $stable(ref_q)));
endmodule

// File: rtl/sar_res_reg.sv
module sar_res_reg #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CHAN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHAN_W-1:0] chan_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CHAN_W-1:0] chan_o
);
  logic              vld_q;
  logic [DATA_W-1:0] data_q;
  logic [CHAN_W-1:0] chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      chan_q <= '0;
    end else if (cap_i) begin
      vld_q  <= 1'b1;
      data_q <= data_i;
      chan_q <= chan_i;
    end else if (ready_i) begin
      vld_q  <= 1'b0;
    end
  end

  assign valid_o = vld_q;
  assign data_o  = data_q;
  assign chan_o  = chan_q;

  assert_res_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !ready_i) |=> (vld_q && $stable(data_q) && $stable(chan_q)));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned P_DATA_W  = DATA_W,
  parameter int unsigned P_CHAN_W  = CHAN_W,
  parameter int unsigned P_REF_W   = REF_W,
  parameter int unsigned P_NUM_CYC = NUM_CYC
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [P_CHAN_W-1:0] req_chan_i,
  input  logic [P_REF_W-1:0]  req_ref_i,
  output logic                adc_soc_o,
  input  logic                adc_eoc_i,
  input  logic [P_DATA_W-1:0] adc_data_i,
  output logic [P_CHAN_W-1:0] adc_chan_sel_o,
  output logic [P_REF_W-1:0]  adc_ref_sel_o,
  output logic                res_valid_o,
  input  logic                res_ready_i,
  output logic [P_DATA_W-1:0] res_data_o,
  output logic [P_CHAN_W-1:0] res_chan_o
);
  localparam int unsigned CNT_W = $clog2(P_NUM_CYC + 1);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(P_NUM_CYC);
  localparam logic [CNT_W-1:0] C_EOC  = CNT_W'(P_NUM_CYC - 1);
  localparam logic [CNT_W-1:0] WIN_LO = CNT_W'(2);
  localparam logic [CNT_W-1:0] WIN_HI = CNT_W'(P_NUM_CYC - 2);

  logic [CNT_W-1:0]    cyc;
  logic                pend_vld;
  logic [P_CHAN_W-1:0] pend_chan;
  logic [P_REF_W-1:0]  pend_ref;
  logic                armed_q;
  logic [P_REF_W-1:0]  nref_q;
  logic [P_CHAN_W-1:0] chan_q, cur_chan_q;
  logic [P_REF_W-1:0]  ref_q;
  logic                at_gap, res_free, soc, in_win, eoc_hit;
  logic                idle_load, mid_load, take;

  assign at_gap    = (cyc == '0) || (cyc == C_LAST);
  assign res_free  = !res_valid_o || res_ready_i;
  assign soc       = armed_q && at_gap && res_free;
  assign in_win    = (cyc >= WIN_LO) && (cyc <= WIN_HI);
  assign eoc_hit   = (cyc == C_EOC) && adc_eoc_i;
  assign idle_load = (cyc == '0) && pend_vld && !armed_q;
  assign mid_load  = in_win && pend_vld && !armed_q;
  assign take      = idle_load || mid_load;

  sar_cycle_cnt #(.NUM_CYC(P_NUM_CYC), .CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (soc),
    .cyc_o   (cyc)
  );

  sar_req_hold #(.CHAN_W(P_CHAN_W), .REF_W(P_REF_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_chan_i  (req_chan_i),
    .req_ref_i   (req_ref_i),
    .take_i      (take),
    .pend_vld_o  (pend_vld),
    .pend_chan_o (pend_chan),
    .pend_ref_o  (pend_ref)
  );

  // armed: selects already hold the next job; reference of a
  // mid-conversion job waits in nref_q until end-of-conversion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      nref_q     <= '0;
      chan_q     <= '0;
      ref_q      <= '0;
      cur_chan_q <= '0;
    end else begin
      if (take) begin
        chan_q  <= pend_chan;
        nref_q  <= pend_ref;
        armed_q <= 1'b1;
        if (idle_load) ref_q <= pend_ref;
      end
      if (soc) begin
        armed_q    <= 1'b0;
        cur_chan_q <= chan_q;
      end
      if (eoc_hit && armed_q) ref_q <= nref_q;
    end
  end

  sar_res_reg #(.DATA_W(P_DATA_W), .CHAN_W(P_CHAN_W)) u_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (eoc_hit),
    .data_i  (adc_data_i),
    .chan_i  (cur_chan_q),
    .valid_o (res_valid_o),
    .ready_i (res_ready_i),
    .data_o  (res_data_o),
    .chan_o  (res_chan_o)
  );

  assign adc_soc_o      = soc;
  assign adc_chan_sel_o = chan_q;
  assign adc_ref_sel_o  = ref_q;

  assert_soc_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_soc_o |=> !adc_soc_o);

  assert_chan_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_chan_sel_o != $past(adc_chan_sel_o)) |->
      ($past(cyc) == '0 || ($past(cyc) >= WIN_LO && $past(cyc) <= WIN_HI)));

  assert_ref_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_ref_sel_o != $past(adc_ref_sel_o)) |->
      ($past(cyc) == '0 || ($past(cyc) == C_EOC && $past(adc_eoc_i))));

  assert_eoc_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_eoc_i |-> cyc == C_EOC);

  assert_eoc_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_hit |=> res_valid_o);

  assert_no_start_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_vld && !armed_q) |-> !adc_soc_o);
endmodule

// File: tb/sar_conv_seq_test.sv
module sar_conv_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [11:0] req_chan = '0;
  logic [1:0]  req_ref = '0;
  logic        res_ready = 1'b1;
  logic        req_ready, soc, eoc, res_valid;
  logic [11:0] adc_data, chan_sel, res_data, res_chan;
  logic [1:0]  ref_sel;

  int checks = 0, errors = 0, viol = 0;
  int cyc_n = 0, n_st = 0, n_log = 0;
  int stamps [0:31];
  logic [11:0] log_data [0:31];
  logic [11:0] log_chan [0:31];
  bit done = 1'b0;

  always #4 clk = ~clk;

  sar_conv_seq uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_chan_i(req_chan), .req_ref_i(req_ref),
    .adc_soc_o(soc), .adc_eoc_i(eoc), .adc_data_i(adc_data),
    .adc_chan_sel_o(chan_sel), .adc_ref_sel_o(ref_sel),
    .res_valid_o(res_valid), .res_ready_i(res_ready),
    .res_data_o(res_data), .res_chan_o(res_chan)
  );

  function automatic logic [11:0] conv_val(logic [11:0] c, logic [1:0] r);
    return c ^ {6{r}};
  endfunction

  // behavioural converter
  logic [3:0]  m_cyc;
  logic [11:0] m_chan;
  logic [1:0]  m_ref;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cyc <= '0; m_chan <= '0; m_ref <= '0;
    end else if ((m_cyc == 0 || m_cyc == 14) && soc) begin
      m_cyc <= 4'd1; m_chan <= chan_sel; m_ref <= ref_sel;
    end else if (m_cyc != 0 && m_cyc < 14) m_cyc <= m_cyc + 4'd1;
    else m_cyc <= '0;
  end
  assign eoc      = (m_cyc == 4'd13);
  assign adc_data = eoc ? conv_val(m_chan, m_ref) : 12'h000;

  // window monitor, soc stamps, result log
  logic [11:0] prev_chan = '0;
  logic [1:0]  prev_ref = '0;
  always @(negedge clk) begin
    cyc_n = cyc_n + 1;
    if (rst_n) begin
      if ((m_cyc == 1 || m_cyc == 14) && chan_sel != prev_chan) viol = viol + 1;
      if (m_cyc >= 1 && m_cyc <= 13 && ref_sel != prev_ref) viol = viol + 1;
      if (soc && n_st < 32) begin stamps[n_st] = cyc_n; n_st = n_st + 1; end
      if (res_valid && res_ready && n_log < 32) begin
        log_data[n_log] = res_data; log_chan[n_log] = res_chan; n_log = n_log + 1;
      end
    end
    prev_chan = chan_sel;
    prev_ref  = ref_sel;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [11:0] c, input logic [1:0] r);
    req_valid = 1'b1; req_chan = c; req_ref = r;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(soc == 0 && res_valid == 0, "R1 soc/valid", {soc, res_valid}, 0);
    chk(chan_sel == 0 && ref_sel == 0, "R1 selects", {chan_sel, ref_sel}, 0);
    chk(req_ready == 1, "R1 req_ready", req_ready, 1);
  endtask

  task automatic t_quiet();
    int hits = 0;
    repeat (30) begin @(negedge clk); if (soc) hits++; end
    chk(hits == 0, "R10 no start", hits, 0);
  endtask

  task automatic t_single();
    int n = 0;
    send(12'h004, 2'd2);
    req_valid = 1'b0;
    while (!soc) @(negedge clk);
    chk(chan_sel == 12'h004, "R2 chan at start", chan_sel, 12'h004);
    chk(ref_sel == 2'd2, "R2 ref at start", ref_sel, 2);
    @(negedge clk);
    chk(soc == 0, "R2 single pulse", soc, 0);
    n = 1;
    while (!res_valid) begin @(negedge clk); n++; end
    chk(n == 14, "R3 latency", n, 14);
    chk(res_data == conv_val(12'h004, 2'd2), "R4 data", res_data, conv_val(12'h004, 2'd2));
    chk(res_chan == 12'h004, "R4 chan", res_chan, 12'h004);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_chain();
    int st0 = n_st, lg0 = n_log;
    logic [11:0] ch [4] = '{12'h001, 12'h080, 12'h400, 12'h010};
    logic [1:0]  rf [4] = '{2'd1, 2'd3, 2'd0, 2'd2};
    for (int i = 0; i < 4; i++) send(ch[i], rf[i]);
    req_valid = 1'b0;
    while (n_log < lg0 + 4) @(negedge clk);
    for (int i = 1; i < 4; i++)
      chk(stamps[st0+i] - stamps[st0+i-1] == 14, "R7 start gap",
          stamps[st0+i] - stamps[st0+i-1], 14);
    for (int i = 0; i < 4; i++) begin
      chk(log_chan[lg0+i] == ch[i], "R7 order", log_chan[lg0+i], ch[i]);
      chk(log_data[lg0+i] == conv_val(ch[i], rf[i]), "R4 chained data",
          log_data[lg0+i], conv_val(ch[i], rf[i]));
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic t_backpressure();
    int lg0, hits = 0;
    logic [11:0] d0;
    res_ready = 1'b0;
    send(12'h200, 2'd1);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    d0 = res_data;
    send(12'h002, 2'd3);
    send(12'h800, 2'd0);
    req_valid = 1'b0;
    chk(req_ready == 0, "R8 hold full", req_ready, 0);
    repeat (20) begin @(negedge clk); if (soc) hits++; end
    chk(hits == 0, "R9 start withheld", hits, 0);
    chk(res_valid == 1 && res_data == d0 && res_chan == 12'h200, "R9 result held",
        res_data, d0);
    chk(req_ready == 0, "R8 still full", req_ready, 0);
    lg0 = n_log;
    res_ready = 1'b1;
    while (n_log < lg0 + 3) @(negedge clk);
    chk(log_chan[lg0] == 12'h200, "R9 first out", log_chan[lg0], 12'h200);
    chk(log_data[lg0+1] == conv_val(12'h002, 2'd3) && log_chan[lg0+1] == 12'h002,
        "R9 second out", log_data[lg0+1], conv_val(12'h002, 2'd3));
    chk(log_data[lg0+2] == conv_val(12'h800, 2'd0) && log_chan[lg0+2] == 12'h800,
        "R8 queued out", log_data[lg0+2], conv_val(12'h800, 2'd0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_quiet();
    t_single();
    t_chain();
    t_backpressure();
    repeat (20) @(negedge clk);
    chk(viol == 0, "R5 R6 select windows", viol, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule